// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable, clocked stand-in for an asynchronous static memory with a 16-bit word made of two independent 8-bit lanes. It is used where a board-level memory of this kind has to live inside a chip or an emulation image. The block samples five active-low controls once per clock and decodes them into one of four access modes: deselected, output disabled, read and write. The controls are a select, an output enable, a write strobe and one enable for each byte lane. In the mode it decodes, it updates or drives only the lanes that are enabled.

The bidirectional bus is split into a write-data input, a read-data output and a per-lane output-enable vector. A pad ring or a bus resolver can rebuild the tri-state bus from these three. A write is held pending for as long as its lane's write overlap lasts. Each sampled cycle of the overlap replaces the pending data. The lane stores the data at the clock edge that first sees the overlap end, whichever control ends it. Read data passes through a fixed pipeline of `READ_LAT` clocks. With `ADDR_W = 17` the array is the full 131,072 words. The default is kept small for elaboration.

Top module: `sram_byte_lane`

## Requirements
- R1: While reset is held, and until reset has been released, `data_oe_o` is 2'b00 whatever the controls are.
- R2: With `sel_n_i` high the block is deselected. `data_oe_o` is 2'b00 and a write strobe has no effect on the stored words.
- R3: With `sel_n_i` low, `wr_n_i` high and `rd_en_n_i` high, `data_oe_o` is 2'b00.
- R4: With `sel_n_i` low and `byte_en_n_i` = 2'b11, `data_oe_o` is 2'b00 and a write strobe stores nothing.
- R5: A read (`sel_n_i` low, `rd_en_n_i` low, `wr_n_i` high, `byte_en_n_i` = 2'b00) drives both lanes: `data_oe_o` = 2'b11 and `data_o` is the stored word.
- R6: Bit 0 of `byte_en_n_i` enables the lower lane, bits 7:0. A read with `byte_en_n_i` = 2'b10 gives `data_oe_o` = 2'b01 and the lower byte of the word.
- R7: Bit 1 of `byte_en_n_i` enables the upper lane, bits 15:8. A read with `byte_en_n_i` = 2'b01 gives `data_oe_o` = 2'b10 and the upper byte of the word.
- R8: A write stores only the lanes whose byte enable is low. The other byte of the addressed word keeps its old value.
- R9: While `sel_n_i` and `wr_n_i` are both low, `data_oe_o` is 2'b00 even with `rd_en_n_i` low.
- R10: A lane's write lasts while `sel_n_i`, `wr_n_i` and that lane's byte enable are all low. The lane stores the data and address of the last sampled cycle of that overlap, whether `wr_n_i`, `sel_n_i` or the byte enable ends it. Each lane ends its write independently.
- R11: Read data and its lane enables appear `READ_LAT` clocks after the read is first sampled (default 1). In the cycle a read starts after a non-read, `data_oe_o` is 2'b00.
- R12: Every address selects its own word: writes to address 0 and to the top address do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Word address |
| sel_n_i | input | 1 | Active-low select |
| rd_en_n_i | input | 1 | Active-low output enable |
| wr_n_i | input | 1 | Active-low write strobe |
| byte_en_n_i | input | 2 | Active-low lane enables, bit 1 upper, bit 0 lower |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data |
| data_oe_o | output | 2 | Per-lane drive enable; a lane at 0 is high impedance |

## Verification
The bench ends a single write in three different ways: through the strobe, through the select and through a byte enable. It changes the write data partway through a pulse. A design that captured data at the start of the overlap, or that committed both lanes when only one ended, would read back a mixed or stale word. It reads with the output enable low during a write, where a design that let the output enable win would drive the bus. It writes one lane over an existing word, where a design without masking would corrupt the other byte. It also checks the first cycle of a read for the pipeline delay, and it probes both ends of the address range.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    ACC_DESEL = 2'd0,
    ACC_HIZ   = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/sbl_decode.sv
module sbl_decode
  import sbl_pkg::*;
(
  input  logic             sel_n,
  input  logic             rd_en_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] byte_en_n,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane
);
  acc_mode_e mode;

  always_comb begin
    if (sel_n)                         mode = ACC_DESEL;
    else if (byte_en_n == '1)          mode = ACC_HIZ;
    else if (!wr_n)                    mode = ACC_WRITE;
    else if (!rd_en_n)                 mode = ACC_READ;
    else                               mode = ACC_HIZ;
  end

  always_comb begin
    wr_lane = '0;
    rd_lane = '0;
    case (mode)
      ACC_WRITE: wr_lane = ~byte_en_n;
      ACC_READ:  rd_lane = ~byte_en_n;
      default: ;
    endcase
  end
endmodule

// File: rtl/sbl_lane.sv
module sbl_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_now,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic              wr_q;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANE_W-1:0] pend_data;
  logic              commit;

  assign commit = wr_q && !wr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_now;
  end

  always_ff @(posedge clk) begin
    if (wr_now) begin
      pend_addr <= addr;
      pend_data <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[pend_addr] <= pend_data;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sbl_rd_pipe.sv
module sbl_rd_pipe #(
  parameter int LAT   = 1,
  parameter int W     = 16,
  parameter int EN_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    d_i,
  input  logic [EN_W-1:0] en_i,
  output logic [W-1:0]    d_o,
  output logic [EN_W-1:0] en_o
);
  generate
    if (LAT == 0) begin : g_comb
      assign d_o  = d_i;
      assign en_o = en_i;
    end else begin : g_reg
      logic [W-1:0]    dq [LAT];
      logic [EN_W-1:0] eq [LAT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < LAT; k++) eq[k] <= '0;
        end else begin
          eq[0] <= en_i;
          for (int k = 1; k < LAT; k++) eq[k] <= eq[k-1];
        end
      end

      always_ff @(posedge clk) begin
        dq[0] <= d_i;
        for (int k = 1; k < LAT; k++) dq[k] <= dq[k-1];
      end

      assign d_o  = dq[LAT-1];
      assign en_o = eq[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
  import sbl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int READ_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_n_i,
  input  logic              rd_en_n_i,
  input  logic              wr_n_i,
  input  logic [1:0]        byte_en_n_i,
  input  logic [15:0]       data_i,
  output logic [15:0]       data_o,
  output logic [1:0]        data_oe_o
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [LANES-1:0]  wr_lane;
  logic [LANES-1:0]  rd_lane;
  logic [WORD_W-1:0] rd_word;
  logic [LANES-1:0]  pipe_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sbl_decode u_decode (
    .sel_n     (sel_n_i),
    .rd_en_n   (rd_en_n_i),
    .wr_n      (wr_n_i),
    .byte_en_n (byte_en_n_i),
    .wr_lane   (wr_lane),
    .rd_lane   (rd_lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbl_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .addr   (addr_i),
      .wr_now (wr_lane[g]),
      .wdata  (data_i[g*LANE_W +: LANE_W]),
      .rdata  (rd_word[g*LANE_W +: LANE_W])
    );
  end

  sbl_rd_pipe #(.LAT(READ_LAT), .W(WORD_W), .EN_W(LANES)) u_pipe (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (rd_word),
    .en_i  (rd_lane),
    .d_o   (data_o),
    .en_o  (pipe_en)
  );

  assign data_oe_o = pipe_en & rd_lane & {LANES{rst_int_n}};
endmodule

// File: rtl/sram_byte_lane_chk.sv
module sram_byte_lane_chk #(
  parameter int READ_LAT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n_i,
  input logic       rd_en_n_i,
  input logic       wr_n_i,
  input logic [1:0] byte_en_n_i,
  input logic [1:0] data_oe_o
);
  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_i |-> data_oe_o == 2'b00);

  // R3
  oe_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_i && wr_n_i && rd_en_n_i) |-> data_oe_o == 2'b00);

  // R6
  low_lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en_n_i[0] |-> !data_oe_o[0]);

  // R7
  high_lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en_n_i[1] |-> !data_oe_o[1]);

  // R9
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_i && !wr_n_i) |-> data_oe_o == 2'b00);

  generate
    if (READ_LAT == 1) begin : g_lat1
      // R11
      read_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o[0] |-> $past(!sel_n_i && !rd_en_n_i && wr_n_i && !byte_en_n_i[0]));
    end
  endgenerate
endmodule

bind sram_byte_lane sram_byte_lane_chk #(.READ_LAT(READ_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_n_i     (sel_n_i),
  .rd_en_n_i   (rd_en_n_i),
  .wr_n_i      (wr_n_i),
  .byte_en_n_i (byte_en_n_i),
  .data_oe_o   (data_oe_o)
);

// File: tb/sram_byte_lane_tb.sv
module sram_byte_lane_tb;
  localparam int AW = 10;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_n, rd_en_n, wr_n;
  logic [1:0]    be_n;
  logic [15:0]   din;
  logic [15:0]   dout;
  logic [1:0]    doe;

  int checks;
  int fails;

  sram_byte_lane #(.ADDR_W(AW), .READ_LAT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .sel_n_i(sel_n),
    .rd_en_n_i(rd_en_n), .wr_n_i(wr_n), .byte_en_n_i(be_n),
    .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic s, logic o, logic w, logic [1:0] b, logic [AW-1:0] a, logic [15:0] d);
    sel_n = s; rd_en_n = o; wr_n = w; be_n = b; addr = a; din = d;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 2'b11, '0, 16'h0);
  endtask

  task automatic write_word(logic [AW-1:0] a, logic [15:0] d, logic [1:0] b);
    drive(1'b0, 1'b1, 1'b0, b, a, d);
    tick();
    idle();
    tick();
  endtask

  task automatic read_word(string req, logic [AW-1:0] a, logic [1:0] b,
                           logic [15:0] exp, logic [1:0] exp_oe);
    drive(1'b0, 1'b0, 1'b1, b, a, 16'h0);
    tick();
    chk(req, {30'd0, doe}, {30'd0, exp_oe});
    if (exp_oe[0]) chk(req, {24'd0, dout[7:0]}, {24'd0, exp[7:0]});
    if (exp_oe[1]) chk(req, {24'd0, dout[15:8]}, {24'd0, exp[15:8]});
    idle();
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 2'b00, '0, 16'h0);
    repeat (3) tick();
    chk("R1", {30'd0, doe}, 32'd0);
    idle();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1", {30'd0, doe}, 32'd0);
  endtask

  task automatic t_full_read();
    write_word(10'h005, 16'hA55A, 2'b00);
    read_word("R5", 10'h005, 2'b00, 16'hA55A, 2'b11);
    write_word(10'h006, 16'h1234, 2'b00);
    read_word("R5", 10'h006, 2'b00, 16'h1234, 2'b11);
  endtask

  task automatic t_lane_read();
    read_word("R6", 10'h005, 2'b10, 16'hA55A, 2'b01);
    read_word("R7", 10'h005, 2'b01, 16'hA55A, 2'b10);
  endtask

  task automatic t_desel();
    drive(1'b1, 1'b0, 1'b1, 2'b00, 10'h005, 16'h0);
    tick();
    chk("R2", {30'd0, doe}, 32'd0);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 10'h005, 16'hFFFF);
    tick();
    idle();
    tick();
    read_word("R2", 10'h005, 2'b00, 16'hA55A, 2'b11);
  endtask

  task automatic t_oe_off();
    drive(1'b0, 1'b1, 1'b1, 2'b00, 10'h005, 16'h0);
    tick();
    chk("R3", {30'd0, doe}, 32'd0);
    idle();
    tick();
  endtask

  task automatic t_no_lanes();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 10'h005, 16'h0);
    tick();
    chk("R4", {30'd0, doe}, 32'd0);
    write_word(10'h005, 16'h0000, 2'b11);
    read_word("R4", 10'h005, 2'b00, 16'hA55A, 2'b11);
  endtask

  task automatic t_masked_write();
    write_word(10'h005, 16'h00C3, 2'b10);
    read_word("R8", 10'h005, 2'b00, 16'hA5C3, 2'b11);
    write_word(10'h005, 16'h7E00, 2'b01);
    read_word("R8", 10'h005, 2'b00, 16'h7EC3, 2'b11);
  endtask

  task automatic t_write_hiz();
    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'h006, 16'h0);
    tick();
    drive(1'b0, 1'b0, 1'b0, 2'b00, 10'h006, 16'hBEEF);
    #1;
    chk("R9", {30'd0, doe}, 32'd0);
    tick();
    chk("R9", {30'd0, doe}, 32'd0);
    idle();
    tick();
    read_word("R9", 10'h006, 2'b00, 16'hBEEF, 2'b11);
  endtask

  task automatic t_terminate();
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'h010, 16'h1111);
    tick();
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'h010, 16'h2222);
    tick();
    drive(1'b0, 1'b1, 1'b1, 2'b00, 10'h010, 16'h3333);
    tick();
    idle();
    tick();
    read_word("R10", 10'h010, 2'b00, 16'h2222, 2'b11);
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'h011, 16'h4444);
    tick();
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'h011, 16'h5555);
    tick();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 10'h011, 16'h6666);
    tick();
    idle();
    tick();
    read_word("R10", 10'h011, 2'b00, 16'h5555, 2'b11);
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'h012, 16'hAAAA);
    tick();
    drive(1'b0, 1'b1, 1'b0, 2'b10, 10'h012, 16'hBBCC);
    tick();
    idle();
    tick();
    read_word("R10", 10'h012, 2'b00, 16'hAACC, 2'b11);
  endtask

  task automatic t_latency();
    idle();
    tick();
    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'h005, 16'h0);
    #1;
    chk("R11", {30'd0, doe}, 32'd0);
    tick();
    chk("R11", {30'd0, doe}, 32'd3);
    chk("R11", {16'd0, dout}, {16'd0, 16'h7EC3});
    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'h006, 16'h0);
    tick();
    chk("R11", {16'd0, dout}, {16'd0, 16'hBEEF});
    idle();
    tick();
  endtask

  task automatic t_addr_ends();
    write_word('0, 16'h0F0F, 2'b00);
    write_word('1, 16'hF00F, 2'b00);
    read_word("R12", '0, 2'b00, 16'h0F0F, 2'b11);
    read_word("R12", '1, 2'b00, 16'hF00F, 2'b11);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    @(negedge clk);
    t_reset();
    t_full_read();
    t_lane_read();
    t_desel();
    t_oe_off();
    t_no_lanes();
    t_masked_write();
    t_write_hiz();
    t_terminate();
    t_latency();
    t_addr_ends();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule